// File: doc/BRIEF.md
# Coprocessor Bus Decoder with Wait States

This block sits between a coprocessor CPU core and the memories that core can reach. Each request carries a 24-bit address and one of four operation kinds: read, write, jump idle or branch idle. For reads and writes the block decodes the address into one of four targets: an I/O register window, program ROM, battery-backed work RAM or internal RAM. An address that hits none of these counts as unmapped. The block drives one select strobe for the chosen target. It holds the access open for a number of cycles set by that target: a fixed base count, plus extra cycles when that target's conflict input is high at the start of the access.

The block keeps a memory address register and a memory data register. Reads of unmapped space return the last byte that crossed the bus. Work-RAM accesses are routed to one of three sub-ports: normal, linear or bitmap. The choice is made from two high address bits.

For jump, call, return and branch instructions the CPU issues an idle request with the program counter on the address lines. The block then inserts the penalty cycles that apply when the code runs from ROM. The handshake is a level request from the CPU that is held until the block raises ready. Ready marks the final cycle of the access, and read data is valid in that cycle.

Top module: `cpbus_wait_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, ready, the write strobe and all select strobes are low, and the address and data registers read zero.
- R2: Operation codes are 0 read, 1 write, 2 jump idle and 3 branch idle. A read or write hits the I/O window when (addr & 0x40FE00) == 0x002200. Only the I/O select is raised, and the access lasts exactly 1 cycle whatever the conflict inputs are.
- R3: An access hits ROM when (addr & 0x408000) == 0x008000 or (addr & 0xC00000) == 0xC00000. It lasts 1 cycle, or 2 when the ROM conflict input is high.
- R4: An access hits work RAM when (addr & 0x40E000) == 0x006000, (addr & 0xE00000) == 0x400000 or (addr & 0xF00000) == 0x600000. It lasts 2 cycles, or 4 when the work-RAM conflict input is high.
- R5: During a work-RAM access exactly one sub-port select is high. It is bitmap when address bits 22 and 21 are both 1, linear when only bit 22 is 1, and normal otherwise. No sub-port select is high during any other access.
- R6: An access hits internal RAM when (addr & 0x40F800) is 0x000000 or 0x003000. It lasts 1 cycle, or 3 when the internal-RAM conflict input is high.
- R7: An access that hits no region lasts 1 cycle and raises no select strobe. A read of it returns the current data register value, and that value stays unchanged.
- R8: Every read or write loads the address register with its address. A write loads the data register with the written byte. A read that hits a region loads the data register with the byte returned by that region.
- R9: The conflict inputs are sampled in the cycle the request is accepted. Changes to them later in the access do not alter its length.
- R10: A jump idle request lasts 1 cycle, or 2 when the ROM conflict input is high, when the program counter decodes as ROM. In every other case it takes no cycle: ready is raised in the request cycle. Idle requests raise no select and no write strobe.
- R11: A branch idle request takes the jump penalty only when program counter bit 0 is 1. Otherwise it takes no cycle.
- R12: The four select strobes are one-hot or all low. They stay high and unchanged for every cycle of an access and are all low when no access is open. Read data is valid in the cycle ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request, held until ready |
| op_i | input | 2 | Operation: 0 read, 1 write, 2 jump idle, 3 branch idle |
| addr_i | input | 24 | Access address, or program counter for idle requests |
| wdata_i | input | 8 | Write byte |
| rom_conflict_i | input | 1 | ROM contention, sampled at acceptance |
| wram_conflict_i | input | 1 | Work-RAM contention, sampled at acceptance |
| iram_conflict_i | input | 1 | Internal-RAM contention, sampled at acceptance |
| io_rdata_i | input | 8 | Read byte from the I/O window |
| rom_rdata_i | input | 8 | Read byte from ROM |
| wram_rdata_i | input | 8 | Read byte from work RAM |
| iram_rdata_i | input | 8 | Read byte from internal RAM |
| ready_o | output | 1 | Final cycle of the request |
| rdata_o | output | 8 | Read result, valid with ready |
| mem_we_o | output | 1 | Write strobe for the open access |
| sel_io_o | output | 1 | I/O window select |
| sel_rom_o | output | 1 | ROM select |
| sel_wram_o | output | 1 | Work-RAM select |
| sel_iram_o | output | 1 | Internal-RAM select |
| wram_normal_o | output | 1 | Work-RAM normal sub-port |
| wram_linear_o | output | 1 | Work-RAM linear sub-port |
| wram_bitmap_o | output | 1 | Work-RAM bitmap sub-port |
| mar_o | output | 24 | Memory address register, also the target address |
| mdr_o | output | 8 | Memory data register, also the write data to targets |

## Verification
Two things can land in the same cycle. The first is a change on a conflict input while an access is already stretching; the second is the final-cycle load of the data register. The bench inverts every conflict input one cycle after each access is accepted. It then checks that the length of the access still follows the values seen at acceptance. It also checks that the returned byte, the data register and the address register come out as the requirement model predicts. Each unmapped read directly follows an access that changed the data register, so a stale or wrongly updated open-bus value is caught.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_JUMP   = 2'd2,
        OP_BRANCH = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_IO   = 3'd1,
        RG_ROM  = 3'd2,
        RG_WRAM = 3'd3,
        RG_IRAM = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        VW_NORMAL = 2'd0,
        VW_LINEAR = 2'd1,
        VW_BITMAP = 2'd2
    } view_e;

    typedef struct packed {
        op_e     op;
        region_e region;
        view_e   view;
    } access_t;

    localparam int NUM_SEL  = 4;
    localparam int NUM_VIEW = 3;

    function automatic logic hits_rom(input logic [ADDR_W-1:0] a);
        return ((a & 24'h408000) == 24'h008000) || ((a & 24'hC00000) == 24'hC00000);
    endfunction

    function automatic logic hits_io(input logic [ADDR_W-1:0] a);
        return (a & 24'h40FE00) == 24'h002200;
    endfunction

    function automatic logic hits_wram(input logic [ADDR_W-1:0] a);
        return ((a & 24'h40E000) == 24'h006000)
            || ((a & 24'hE00000) == 24'h400000)
            || ((a & 24'hF00000) == 24'h600000);
    endfunction

    function automatic logic hits_iram(input logic [ADDR_W-1:0] a);
        return ((a & 24'h40F800) == 24'h000000) || ((a & 24'h40F800) == 24'h003000);
    endfunction

    // Priority: I/O window, ROM, work RAM, internal RAM.
    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        if (hits_io(a))        r = RG_IO;
        else if (hits_rom(a))  r = RG_ROM;
        else if (hits_wram(a)) r = RG_WRAM;
        else if (hits_iram(a)) r = RG_IRAM;
        else                   r = RG_NONE;
        return r;
    endfunction

    function automatic view_e wram_view(input logic [ADDR_W-1:0] a);
        view_e v;
        if (a[22] && a[21]) v = VW_BITMAP;
        else if (a[22])     v = VW_LINEAR;
        else                v = VW_NORMAL;
        return v;
    endfunction

    function automatic logic is_mem_op(input op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/cpbus_region_decode.sv
module cpbus_region_decode
    import cpbus_pkg::*;
#(
    parameter int IO_BASE    = 1,
    parameter int ROM_BASE   = 1,
    parameter int ROM_EXTRA  = 1,
    parameter int WRAM_BASE  = 2,
    parameter int WRAM_EXTRA = 2,
    parameter int IRAM_BASE  = 1,
    parameter int IRAM_EXTRA = 2,
    parameter int MISS_BASE  = 1,
    parameter int JUMP_BASE  = 1,
    parameter int JUMP_EXTRA = 1,
    parameter int CNT_W      = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  op_e               op_i,
    input  logic              rom_conflict_i,
    input  logic              wram_conflict_i,
    input  logic              iram_conflict_i,
    output access_t           acc_o,
    output logic [CNT_W-1:0]  cycles_o
);

    region_e region_raw;
    logic    jump_due;

    always_comb begin
        region_raw = decode_region(addr_i);
        jump_due   = hits_rom(addr_i) && ((op_i == OP_JUMP) || addr_i[0]);

        acc_o.op     = op_i;
        acc_o.region = is_mem_op(op_i) ? region_raw : RG_NONE;
        acc_o.view   = wram_view(addr_i);

        cycles_o = '0;
        if (is_mem_op(op_i)) begin
            unique case (region_raw)
                RG_IO:   cycles_o = CNT_W'(IO_BASE);
                RG_ROM:  cycles_o = CNT_W'(ROM_BASE)
                                  + (rom_conflict_i ? CNT_W'(ROM_EXTRA) : '0);
                RG_WRAM: cycles_o = CNT_W'(WRAM_BASE)
                                  + (wram_conflict_i ? CNT_W'(WRAM_EXTRA) : '0);
                RG_IRAM: cycles_o = CNT_W'(IRAM_BASE)
                                  + (iram_conflict_i ? CNT_W'(IRAM_EXTRA) : '0);
                default: cycles_o = CNT_W'(MISS_BASE);
            endcase
        end else if (jump_due) begin
            cycles_o = CNT_W'(JUMP_BASE) + (rom_conflict_i ? CNT_W'(JUMP_EXTRA) : '0);
        end
    end

endmodule

// File: rtl/cpbus_wait_timer.sv
module cpbus_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cycles_i,
    output logic             active_o,
    output logic             last_o
);

    logic [CNT_W-1:0] remain_q;
    logic             active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            remain_q <= cycles_i - CNT_W'(1);
        end else if (active_q) begin
            if (remain_q == '0) active_q <= 1'b0;
            else                remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign active_o = active_q;
    assign last_o   = active_q && (remain_q == '0);

endmodule

// File: rtl/cpbus_data_regs.sv
module cpbus_data_regs
    import cpbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  op_e               start_op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              finish_read_hit_i,
    input  logic [DATA_W-1:0] hit_data_i,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] mdr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_o <= '0;
            mdr_o <= '0;
        end else begin
            if (start_i && is_mem_op(start_op_i)) mar_o <= addr_i;
            if (start_i && (start_op_i == OP_WRITE)) mdr_o <= wdata_i;
            else if (finish_read_hit_i)              mdr_o <= hit_data_i;
        end
    end

endmodule

// File: rtl/cpbus_wait_decoder.sv
module cpbus_wait_decoder
    import cpbus_pkg::*;
#(
    parameter int IO_BASE    = 1,
    parameter int ROM_BASE   = 1,
    parameter int ROM_EXTRA  = 1,
    parameter int WRAM_BASE  = 2,
    parameter int WRAM_EXTRA = 2,
    parameter int IRAM_BASE  = 1,
    parameter int IRAM_EXTRA = 2,
    parameter int MISS_BASE  = 1,
    parameter int JUMP_BASE  = 1,
    parameter int JUMP_EXTRA = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [1:0]  op_i,
    input  logic [23:0] addr_i,
    input  logic [7:0]  wdata_i,
    input  logic        rom_conflict_i,
    input  logic        wram_conflict_i,
    input  logic        iram_conflict_i,
    input  logic [7:0]  io_rdata_i,
    input  logic [7:0]  rom_rdata_i,
    input  logic [7:0]  wram_rdata_i,
    input  logic [7:0]  iram_rdata_i,
    output logic        ready_o,
    output logic [7:0]  rdata_o,
    output logic        mem_we_o,
    output logic        sel_io_o,
    output logic        sel_rom_o,
    output logic        sel_wram_o,
    output logic        sel_iram_o,
    output logic        wram_normal_o,
    output logic        wram_linear_o,
    output logic        wram_bitmap_o,
    output logic [23:0] mar_o,
    output logic [7:0]  mdr_o
);

    localparam int MAX_CYC = IO_BASE + ROM_BASE + ROM_EXTRA + WRAM_BASE + WRAM_EXTRA
                           + IRAM_BASE + IRAM_EXTRA + MISS_BASE + JUMP_BASE + JUMP_EXTRA;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    access_t            acc_now;
    access_t            acc_q;
    logic [CNT_W-1:0]   cycles_now;
    logic               acc_active;
    logic               acc_last;
    logic               start;
    logic               no_wait;
    logic [NUM_SEL-1:0] sel_vec;
    logic [NUM_VIEW-1:0] view_vec;
    logic [DATA_W-1:0]  hit_data;
    logic               hit;

    cpbus_region_decode #(
        .IO_BASE   (IO_BASE),
        .ROM_BASE  (ROM_BASE),
        .ROM_EXTRA (ROM_EXTRA),
        .WRAM_BASE (WRAM_BASE),
        .WRAM_EXTRA(WRAM_EXTRA),
        .IRAM_BASE (IRAM_BASE),
        .IRAM_EXTRA(IRAM_EXTRA),
        .MISS_BASE (MISS_BASE),
        .JUMP_BASE (JUMP_BASE),
        .JUMP_EXTRA(JUMP_EXTRA),
        .CNT_W     (CNT_W)
    ) i_decode (
        .addr_i         (addr_i),
        .op_i           (op_e'(op_i)),
        .rom_conflict_i (rom_conflict_i),
        .wram_conflict_i(wram_conflict_i),
        .iram_conflict_i(iram_conflict_i),
        .acc_o          (acc_now),
        .cycles_o       (cycles_now)
    );

    assign no_wait = req_i && !acc_active && (cycles_now == '0);
    assign start   = req_i && !acc_active && (cycles_now != '0);

    cpbus_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .cycles_i(cycles_now),
        .active_o(acc_active),
        .last_o  (acc_last)
    );

    always_ff @(posedge clk) begin
        if (rst)        acc_q <= '{op: OP_READ, region: RG_NONE, view: VW_NORMAL};
        else if (start) acc_q <= acc_now;
    end

    // One strobe per target region, index = region code - 1.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_vec[g] = acc_active && (acc_q.region == region_e'(g + 1));
    end

    for (genvar g = 0; g < NUM_VIEW; g++) begin : g_view
        assign view_vec[g] = sel_vec[RG_WRAM - 1] && (acc_q.view == view_e'(g));
    end

    always_comb begin
        unique case (acc_q.region)
            RG_IO:   hit_data = io_rdata_i;
            RG_ROM:  hit_data = rom_rdata_i;
            RG_WRAM: hit_data = wram_rdata_i;
            RG_IRAM: hit_data = iram_rdata_i;
            default: hit_data = '0;
        endcase
    end

    assign hit = acc_q.region != RG_NONE;

    cpbus_data_regs i_regs (
        .clk              (clk),
        .rst              (rst),
        .start_i          (start),
        .start_op_i       (acc_now.op),
        .addr_i           (addr_i),
        .wdata_i          (wdata_i),
        .finish_read_hit_i(acc_last && hit && (acc_q.op == OP_READ)),
        .hit_data_i       (hit_data),
        .mar_o            (mar_o),
        .mdr_o            (mdr_o)
    );

    assign ready_o       = acc_last || no_wait;
    assign rdata_o       = (acc_active && hit) ? hit_data : mdr_o;
    assign mem_we_o      = acc_active && (acc_q.op == OP_WRITE);
    assign sel_io_o      = sel_vec[RG_IO - 1];
    assign sel_rom_o     = sel_vec[RG_ROM - 1];
    assign sel_wram_o    = sel_vec[RG_WRAM - 1];
    assign sel_iram_o    = sel_vec[RG_IRAM - 1];
    assign wram_normal_o = view_vec[VW_NORMAL];
    assign wram_linear_o = view_vec[VW_LINEAR];
    assign wram_bitmap_o = view_vec[VW_BITMAP];

endmodule

// File: rtl/cpbus_checker.sv
module cpbus_checker (
    input logic        clk,
    input logic        rst,
    input logic        acc_active,
    input logic        ready_o,
    input logic        mem_we_o,
    input logic [3:0]  sels,
    input logic [2:0]  views,
    input logic [23:0] mar_o
);

    p_sel_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sels));

    p_idle_no_sel_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_active |-> (sels == 4'b0 && !mem_we_o));

    p_sel_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_active && $past(acc_active) && !$past(ready_o)) |-> $stable(sels));

    p_view_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        sels[2] |-> $countones(views) == 1);

    p_view_only_wram_r5: assert property (@(posedge clk) disable iff (rst)
        !sels[2] |-> views == 3'b0);

    p_mar_held_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_active && $past(acc_active) && !$past(ready_o)) |-> $stable(mar_o));

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (sels == 4'b0 && mar_o == 24'h0));

endmodule

bind cpbus_wait_decoder cpbus_checker i_checker (
    .clk       (clk),
    .rst       (rst),
    .acc_active(acc_active),
    .ready_o   (ready_o),
    .mem_we_o  (mem_we_o),
    .sels      ({sel_iram_o, sel_wram_o, sel_rom_o, sel_io_o}),
    .views     ({wram_bitmap_o, wram_linear_o, wram_normal_o}),
    .mar_o     (mar_o)
);

// File: tb/test_cpbus_wait_decoder.sv
module test_cpbus_wait_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rc = 1'b0, wc = 1'b0, ic = 1'b0;
    logic        ready, we;
    logic [7:0]  rdata, mdr;
    logic        s_io, s_rom, s_wram, s_iram, v_n, v_l, v_b;
    logic [23:0] mar;

    localparam logic [7:0] IO_VAL = 8'h11, ROM_VAL = 8'h22, WRAM_VAL = 8'h33, IRAM_VAL = 8'h44;

    always #4 clk = ~clk;

    cpbus_wait_decoder i_cpbus_wait_decoder (
        .clk(clk), .rst(rst), .req_i(req), .op_i(op), .addr_i(addr), .wdata_i(wdata),
        .rom_conflict_i(rc), .wram_conflict_i(wc), .iram_conflict_i(ic),
        .io_rdata_i(IO_VAL), .rom_rdata_i(ROM_VAL), .wram_rdata_i(WRAM_VAL),
        .iram_rdata_i(IRAM_VAL), .ready_o(ready), .rdata_o(rdata), .mem_we_o(we),
        .sel_io_o(s_io), .sel_rom_o(s_rom), .sel_wram_o(s_wram), .sel_iram_o(s_iram),
        .wram_normal_o(v_n), .wram_linear_o(v_l), .wram_bitmap_o(v_b),
        .mar_o(mar), .mdr_o(mdr)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [23:0] addr;
        logic [7:0]  wd;
        logic        rc, wc, ic;
        logic [2:0]  cyc;
        logic [3:0]  sel;   // {iram, wram, rom, io}
        logic [2:0]  view;  // {bitmap, linear, normal}
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 24'h002200, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0001, 3'b000}, // R2
        '{2'd0, 24'h8023FF, 8'h00, 1'b1, 1'b1, 1'b1, 3'd1, 4'b0001, 3'b000}, // R2
        '{2'd0, 24'h008000, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0010, 3'b000}, // R3
        '{2'd0, 24'h00FFFF, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2, 4'b0010, 3'b000}, // R3
        '{2'd1, 24'hC01234, 8'h5A, 1'b1, 1'b0, 1'b0, 3'd2, 4'b0010, 3'b000}, // R3 R8
        '{2'd0, 24'h006000, 8'h00, 1'b0, 1'b1, 1'b0, 3'd4, 4'b0100, 3'b001}, // R4 R5
        '{2'd0, 24'h407000, 8'h00, 1'b0, 1'b0, 1'b0, 3'd2, 4'b0100, 3'b010}, // R4 R5
        '{2'd1, 24'h601234, 8'hA5, 1'b0, 1'b1, 1'b0, 3'd4, 4'b0100, 3'b100}, // R4 R5
        '{2'd0, 24'h002000, 8'h00, 1'b1, 1'b1, 1'b1, 3'd1, 4'b0000, 3'b000}, // R7
        '{2'd0, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b1000, 3'b000}, // R6
        '{2'd0, 24'h803000, 8'h00, 1'b0, 1'b0, 1'b1, 3'd3, 4'b1000, 3'b000}, // R6
        '{2'd1, 24'h703000, 8'h3C, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0000, 3'b000}, // R7 R8
        '{2'd0, 24'h7FFFFF, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0000, 3'b000}, // R7
        '{2'd2, 24'h008000, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0000, 3'b000}, // R10
        '{2'd2, 24'hC00000, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2, 4'b0000, 3'b000}, // R10
        '{2'd2, 24'h006000, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0, 4'b0000, 3'b000}, // R10
        '{2'd3, 24'h008001, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2, 4'b0000, 3'b000}, // R11
        '{2'd3, 24'h008002, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 4'b0000, 3'b000}, // R11
        '{2'd3, 24'h000101, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0, 4'b0000, 3'b000}, // R11
        '{2'd0, 24'h6FFFFF, 8'h00, 1'b0, 1'b0, 1'b0, 3'd2, 4'b0100, 3'b100}  // R5 R9
    };

    int checks = 0;
    int errors = 0;
    logic [7:0]  exp_mdr = '0;
    logic [23:0] exp_mar = '0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req_tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    function automatic logic [7:0] region_value(input logic [3:0] sel);
        if (sel[0]) return IO_VAL;
        if (sel[1]) return ROM_VAL;
        if (sel[2]) return WRAM_VAL;
        if (sel[3]) return IRAM_VAL;
        return 8'h00;
    endfunction

    task automatic run_vec(input vec_t v);
        int n;
        logic [7:0] got;
        logic [7:0] exp_rd;
        n = 0;
        @(negedge clk);
        op = v.op; addr = v.addr; wdata = v.wd; rc = v.rc; wc = v.wc; ic = v.ic; req = 1'b1;
        #1;
        if (!ready) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                n++;
                if (n == 1) begin
                    rc = ~rc; wc = ~wc; ic = ~ic; // R9: later changes must not matter
                    check({s_iram, s_wram, s_rom, s_io} == v.sel, "R12 select",
                          {s_iram, s_wram, s_rom, s_io}, v.sel);
                    check({v_b, v_l, v_n} == v.view, "R5 sub-port", {v_b, v_l, v_n}, v.view);
                    check(we == (v.op == 2'd1), "R10 write strobe", we, v.op == 2'd1);
                end
                if (ready) break;
            end
        end
        got = rdata;
        req = 1'b0;
        check(n == int'(v.cyc), "R9 cycles (R2 R3 R4 R6 R7 R10 R11)", n, v.cyc);
        if (v.op == 2'd0) begin
            exp_rd = (v.sel != 4'b0) ? region_value(v.sel) : exp_mdr;
            check(got == exp_rd, "R7 read data", got, exp_rd);
            exp_mdr = exp_rd;
        end else if (v.op == 2'd1) begin
            exp_mdr = v.wd;
        end
        if (v.op < 2'd2) exp_mar = v.addr;
        @(negedge clk);
        check(mar == exp_mar, "R8 address register", mar, exp_mar);
        check(mdr == exp_mdr, "R8 data register", mdr, exp_mdr);
        check({s_iram, s_wram, s_rom, s_io, we} == 5'b0, "R12 idle strobes",
              {s_iram, s_wram, s_rom, s_io, we}, 0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ready && {s_iram, s_wram, s_rom, s_io} == 4'b0, "R1 in reset",
              {ready, s_iram, s_wram, s_rom, s_io}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mar == 24'h0 && mdr == 8'h0 && !we && !ready, "R1 after reset",
              {mar, mdr}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: unmapped read right after a hit read returns the hit byte.
        run_vec('{2'd0, 24'h000200, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b1000, 3'b000});
        run_vec('{2'd0, 24'h7E0000, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 4'b0000, 3'b000});
        check(mdr == IRAM_VAL, "R7 open bus held", mdr, IRAM_VAL);

        // R1: reset in the middle of a stretched work-RAM access.
        @(negedge clk);
        op = 2'd1; addr = 24'h006100; wdata = 8'h77; wc = 1'b1; req = 1'b1;
        @(negedge clk);
        req = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({s_iram, s_wram, s_rom, s_io, we, ready} == 6'b0 && mar == 0 && mdr == 0,
              "R1 reset mid access", {mar, mdr}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule